// File: doc/BRIEF.md
# Task-Switch Segment Selector Checker

During a hardware task switch, a processor reloads the LDT register and the segment registers from the incoming task state. For each register, once the descriptor fetch has completed, the selector and the descriptor's access fields have to be qualified. This unit performs that qualification for one selector per request. It accepts these inputs:

- the kind of register being loaded;
- the raw 16-bit selector;
- the access byte of the fetched descriptor;
- a flag saying whether the fetch succeeded;
- the requested privilege level of the incoming code selector.

One clock later it returns:

- a pass/fail verdict;
- whether the descriptor cache may be marked valid;
- the fault class to raise;
- the error code that goes with the fault.

Each register kind has its own rules. A null selector is legal for the LDT and for the data registers, and fatal for the stack and code registers. The fault class also depends on the kind: a missing stack segment raises a stack fault, and a missing LDT raises invalid-TSS. The sequencer that walks the descriptor tables issues one request per register and reads back the registered verdict. Table walking and memory access are outside this block.

Top module: `ts_seg_check`

## Requirements
- R1: The result of a request presented with `reqValid` high at a rising edge appears on the outputs after that edge. `doneValid` is high for exactly that one cycle. While `reqValid` stays low, `pass`, `cacheValid`, `faultCode` and `errCode` hold their values.
- R2: A selector is null when bits 15:2 are all zero. Null is accepted with `cacheValid`=0 for kind LDT (0) and kind DATA (3). It gives `faultCode`=1 (invalid-TSS) for kind SS (1) and kind CS (2). The fetch flag and the access byte are ignored for a null selector.
- R3: `errCode` equals the request selector with bits 1:0 cleared, for every request, whether it passes or fails.
- R4: For a non-null selector with `fetchOk`=0, the result is `faultCode`=1, whatever the access byte holds.
- R5: For kind LDT, a selector with bit 2 (table indicator) set faults with code 1. So does a descriptor with S (access bit 4)=1, or with type (access bits 3:0) other than 2. A descriptor that is not present (access bit 7=0) also faults with code 1.
- R6: For kind SS, the descriptor must have S=1, code (bit 3)=0 and writable (bit 1)=1, or the fault is 1. DPL (bits 6:5) must equal both `csRpl` and the selector RPL (bits 1:0), or the fault is 1. A descriptor that passes both checks but is not present faults with code 3 (stack).
- R7: For kind CS, the descriptor must have S=1 and code=1, or the fault is 1. With conforming (bit 2)=0, DPL must equal the RPL. With conforming=1, DPL must be at most the RPL. A privilege failure faults with code 1. A descriptor that is not present faults with code 2 (not-present).
- R8: For kind DATA, the descriptor must be a data segment, or a code segment with readable=1, or the fault is 1. For data segments and non-conforming code, the RPL and `csRpl` must both be at most DPL, or the fault is 1. A descriptor that is not present faults with code 2.
- R9: Checks are applied in this order, and the first failing one decides the fault: fetch, then type, then privilege, then presence.
- R10: After reset, `doneValid`, `pass`, `cacheValid`, `faultCode` and `errCode` are all zero.
- R11: `pass` is high exactly when `faultCode` is 0. `cacheValid` is high exactly when a non-null selector passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; the other inputs are sampled with it |
| regKind | input | 2 | 0 LDT, 1 SS, 2 CS, 3 data register |
| selector | input | 16 | Raw selector being loaded |
| accessByte | input | 8 | Descriptor access byte: P, DPL[1:0], S, code, conforming, R/W, accessed |
| fetchOk | input | 1 | Descriptor fetch succeeded |
| csRpl | input | 2 | RPL of the new code selector |
| doneValid | output | 1 | One-cycle pulse marking a fresh result |
| pass | output | 1 | Selector accepted |
| cacheValid | output | 1 | Descriptor cache may be marked valid |
| faultCode | output | 2 | 0 none, 1 invalid-TSS, 2 not-present, 3 stack fault |
| errCode | output | 16 | Error code to push with the fault |

## Verification
Every result is registered once, so the verdict, cache flag, fault code and error code are all due one cycle after the edge that samples `reqValid`. The bench drives a request on a falling edge, lets one rising edge capture it, and compares all outputs on the next falling edge, where `doneValid` must also be high. It then drops `reqValid`, scrambles the other inputs, and checks one cycle later that `doneValid` has fallen and the other outputs have held.

// File: rtl/ts_seg_pkg.sv
package ts_seg_pkg;
  localparam int SEL_W = 16;
  localparam int ACC_W = 8;
  localparam int PL_W  = 2;

  // access byte bit positions
  localparam int ACC_P    = 7;
  localparam int ACC_DPLH = 6;
  localparam int ACC_DPLL = 5;
  localparam int ACC_S    = 4;
  localparam int ACC_CODE = 3;
  localparam int ACC_CONF = 2;
  localparam int ACC_RW   = 1;
  localparam int SEL_TI   = 2;
  localparam logic [3:0] LDT_TYPE = 4'h2;

  typedef enum logic [1:0] {
    KIND_LDT  = 2'd0,
    KIND_SS   = 2'd1,
    KIND_CS   = 2'd2,
    KIND_DATA = 2'd3
  } regKind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TS    = 2'd1,
    FLT_NP    = 2'd2,
    FLT_STACK = 2'd3
  } fault_e;

  typedef struct packed {
    logic   load;
    logic   pass;
    logic   cacheSet;
    fault_e fault;
  } ctlStrobe_t;
endpackage

// File: rtl/ts_seg_ctrl.sv
module ts_seg_ctrl
  import ts_seg_pkg::*;
#(
  parameter int SelW = SEL_W,
  parameter int AccW = ACC_W
) (
  input  logic            reqValid,
  input  logic [1:0]      regKind,
  input  logic [SelW-1:0] selector,
  input  logic [AccW-1:0] accessByte,
  input  logic            fetchOk,
  input  logic [PL_W-1:0] csRpl,
  output ctlStrobe_t      strobe
);
  logic            nullSel, tiBit, present, sFlag, isCode, conf, rw;
  logic [PL_W-1:0] rpl, dpl;
  logic            preFault, nullOk, typeOk, privOk;
  fault_e          presFault, verdict;

  always_comb begin
    nullSel = ~|selector[SelW-1:2];
    tiBit   = selector[SEL_TI];
    rpl     = selector[1:0];
    present = accessByte[ACC_P];
    dpl     = accessByte[ACC_DPLH:ACC_DPLL];
    sFlag   = accessByte[ACC_S];
    isCode  = accessByte[ACC_CODE];
    conf    = accessByte[ACC_CONF];
    rw      = accessByte[ACC_RW];
  end

  // per-kind rule set
  always_comb begin
    preFault  = 1'b0;
    nullOk    = 1'b0;
    typeOk    = 1'b0;
    privOk    = 1'b1;
    presFault = FLT_NP;
    unique case (regKind_e'(regKind))
      KIND_LDT: begin
        preFault  = tiBit;
        nullOk    = 1'b1;
        typeOk    = !sFlag && (accessByte[3:0] == LDT_TYPE);
        presFault = FLT_TS;
      end
      KIND_SS: begin
        typeOk    = sFlag && !isCode && rw;
        privOk    = (dpl == csRpl) && (dpl == rpl);
        presFault = FLT_STACK;
      end
      KIND_CS: begin
        typeOk = sFlag && isCode;
        privOk = conf ? (dpl <= rpl) : (dpl == rpl);
      end
      default: begin
        nullOk = 1'b1;
        typeOk = sFlag && (!isCode || rw);
        privOk = (isCode && conf) || ((rpl <= dpl) && (csRpl <= dpl));
      end
    endcase
  end

  // priority chain: selector form, fetch, type, privilege, presence
  always_comb begin
    verdict         = FLT_NONE;
    strobe.cacheSet = 1'b0;
    if (preFault)          verdict = FLT_TS;
    else if (nullSel)      verdict = nullOk ? FLT_NONE : FLT_TS;
    else if (!fetchOk)     verdict = FLT_TS;
    else if (!typeOk)      verdict = FLT_TS;
    else if (!privOk)      verdict = FLT_TS;
    else if (!present)     verdict = presFault;
    else                   strobe.cacheSet = 1'b1;
    strobe.load  = reqValid;
    strobe.fault = verdict;
    strobe.pass  = (verdict == FLT_NONE);
  end
endmodule

// File: rtl/ts_seg_dpath.sv
module ts_seg_dpath
  import ts_seg_pkg::*;
#(
  parameter int SelW = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [SelW-1:0] selector,
  output logic            doneValid,
  output logic            pass,
  output logic            cacheValid,
  output logic [1:0]      faultCode,
  output logic [SelW-1:0] errCode
);
  localparam logic [SelW-1:0] ERR_MASK = {{(SelW-2){1'b1}}, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      pass       <= 1'b0;
      cacheValid <= 1'b0;
      faultCode  <= FLT_NONE;
      errCode    <= '0;
    end else begin
      doneValid <= strobe.load;
      if (strobe.load) begin
        pass       <= strobe.pass;
        cacheValid <= strobe.cacheSet;
        faultCode  <= strobe.fault;
        errCode    <= selector & ERR_MASK;
      end
    end
  end
endmodule

// File: rtl/ts_seg_check.sv
module ts_seg_check
  import ts_seg_pkg::*;
#(
  parameter int SelW = SEL_W,
  parameter int AccW = ACC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [1:0]      regKind,
  input  logic [SelW-1:0] selector,
  input  logic [AccW-1:0] accessByte,
  input  logic            fetchOk,
  input  logic [PL_W-1:0] csRpl,
  output logic            doneValid,
  output logic            pass,
  output logic            cacheValid,
  output logic [1:0]      faultCode,
  output logic [SelW-1:0] errCode
);
  ctlStrobe_t strobe;

  ts_seg_ctrl #(.SelW(SelW), .AccW(AccW)) u_ctrl (
    .reqValid(reqValid), .regKind(regKind), .selector(selector),
    .accessByte(accessByte), .fetchOk(fetchOk), .csRpl(csRpl),
    .strobe(strobe)
  );

  ts_seg_dpath #(.SelW(SelW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selector(selector),
    .doneValid(doneValid), .pass(pass), .cacheValid(cacheValid),
    .faultCode(faultCode), .errCode(errCode)
  );
endmodule

// File: rtl/ts_seg_check_sva.sv
module ts_seg_check_sva
  import ts_seg_pkg::*;
#(
  parameter int SelW = SEL_W,
  parameter int AccW = ACC_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [1:0]      regKind,
  input logic [SelW-1:0] selector,
  input logic [AccW-1:0] accessByte,
  input logic            fetchOk,
  input logic            doneValid,
  input logic            pass,
  input logic            cacheValid,
  input logic [1:0]      faultCode,
  input logic [SelW-1:0] errCode
);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneValid);
  p_done_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneValid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(pass) && $stable(cacheValid) && $stable(faultCode) && $stable(errCode)));
  p_err_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (errCode == {$past(selector[SelW-1:2]), 2'b00}));
  p_null_stack_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (regKind == KIND_SS || regKind == KIND_CS) && selector[SelW-1:2] == '0)
      |=> (faultCode == FLT_TS));
  p_fetch_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !fetchOk && selector[SelW-1:2] != '0) |=> (faultCode == FLT_TS && !pass));
  p_stack_only_ss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && regKind != KIND_SS) |=> (faultCode != FLT_STACK));
  p_ldt_no_np_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && regKind == KIND_LDT) |=> (faultCode != FLT_NP));
  p_pass_none_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (pass == (faultCode == FLT_NONE)));
  p_cache_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    cacheValid |-> pass);
  p_absent_cache_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !accessByte[ACC_P]) |=> !cacheValid);
endmodule

bind ts_seg_check ts_seg_check_sva #(.SelW(SelW), .AccW(AccW)) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .regKind(regKind),
  .selector(selector), .accessByte(accessByte), .fetchOk(fetchOk),
  .doneValid(doneValid), .pass(pass), .cacheValid(cacheValid),
  .faultCode(faultCode), .errCode(errCode)
);

// File: tb/sim_ts_seg_check.sv
module sim_ts_seg_check;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 600;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  regKind = '0;
  logic [15:0] selector = '0;
  logic [7:0]  accessByte = '0;
  logic        fetchOk = 1'b0;
  logic [1:0]  csRpl = '0;
  logic        doneValid, pass, cacheValid;
  logic [1:0]  faultCode;
  logic [15:0] errCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_seg_check u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .regKind(regKind),
    .selector(selector), .accessByte(accessByte), .fetchOk(fetchOk),
    .csRpl(csRpl), .doneValid(doneValid), .pass(pass),
    .cacheValid(cacheValid), .faultCode(faultCode), .errCode(errCode)
  );

  // expected fault code: 0 none, 1 invalid-TSS, 2 not-present, 3 stack
  function automatic logic [1:0] expFault(input logic [1:0] k, input logic [15:0] s,
                                          input logic [7:0] a, input logic f,
                                          input logic [1:0] cr);
    logic [1:0] r = s[1:0];
    logic [1:0] d = a[6:5];
    bit isNull = (s[15:2] == 14'd0);
    if (k == 2'd0 && s[2]) return 2'd1;               // R5 table indicator
    if (isNull) return (k == 2'd1 || k == 2'd2) ? 2'd1 : 2'd0; // R2
    if (!f) return 2'd1;                              // R4
    case (k)
      2'd0: begin
        if (a[4] || a[3:0] != 4'h2) return 2'd1;
        return a[7] ? 2'd0 : 2'd1;
      end
      2'd1: begin
        if (!(a[4] && !a[3] && a[1])) return 2'd1;
        if (!(d == cr && d == r)) return 2'd1;
        return a[7] ? 2'd0 : 2'd3;
      end
      2'd2: begin
        if (!(a[4] && a[3])) return 2'd1;
        if (a[2] ? (d > r) : (d != r)) return 2'd1;
        return a[7] ? 2'd0 : 2'd2;
      end
      default: begin
        if (!a[4] || (a[3] && !a[1])) return 2'd1;
        if (!(a[3] && a[2]) && (r > d || cr > d)) return 2'd1;
        return a[7] ? 2'd0 : 2'd2;
      end
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one request, check result one cycle later, then check hold
  task automatic apply(input string tag, input logic [1:0] k, input logic [15:0] s,
                       input logic [7:0] a, input logic f, input logic [1:0] cr);
    logic [1:0] ef = expFault(k, s, a, f, cr);
    bit isNull = (s[15:2] == 14'd0);
    @(negedge clk);
    reqValid = 1'b1; regKind = k; selector = s; accessByte = a; fetchOk = f; csRpl = cr;
    @(negedge clk);
    chk("R1", 32'(doneValid), 32'd1, "doneValid");
    chk(tag, 32'(faultCode), 32'(ef), "faultCode");
    chk("R11", 32'(pass), 32'(ef == 2'd0), "pass");
    chk("R11", 32'(cacheValid), 32'(ef == 2'd0 && !isNull), "cacheValid");
    chk("R3", 32'(errCode), 32'(s & 16'hFFFC), "errCode");
    reqValid = 1'b0;
    selector = 16'($urandom); accessByte = 8'($urandom); regKind = 2'($urandom);
    @(negedge clk);
    chk("R1", 32'(doneValid), 32'd0, "doneValid after");
    chk("R1", 32'({pass, cacheValid, faultCode, errCode}),
        32'({ef == 2'd0, ef == 2'd0 && !isNull, ef, s & 16'hFFFC}), "held result");
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R10", 32'({doneValid, pass, cacheValid, faultCode}), 32'd0, "reset flags");
    chk("R10", 32'(errCode), 32'd0, "reset errCode");
    rstN = 1'b1;

    // R2 null handling per kind, access byte garbage
    apply("R2", 2'd0, 16'h0003, 8'h00, 1'b0, 2'd0);
    apply("R2", 2'd3, 16'h0002, 8'h00, 1'b0, 2'd3);
    apply("R2", 2'd1, 16'h0001, 8'hF3, 1'b1, 2'd1);
    apply("R2", 2'd2, 16'h0000, 8'h9A, 1'b1, 2'd0);
    // R4 fetch failure on an otherwise good CS
    apply("R4", 2'd2, 16'h0008, 8'h9A, 1'b0, 2'd0);
    // R5 LDT
    apply("R5", 2'd0, 16'h0028, 8'h82, 1'b1, 2'd0);
    apply("R5", 2'd0, 16'h002C, 8'h82, 1'b1, 2'd0);
    apply("R5", 2'd0, 16'h0028, 8'h02, 1'b1, 2'd0);
    apply("R5", 2'd0, 16'h0028, 8'h89, 1'b1, 2'd0);
    // R6 SS
    apply("R6", 2'd1, 16'h0013, 8'hF2, 1'b1, 2'd3);
    apply("R6", 2'd1, 16'h0013, 8'h72, 1'b1, 2'd3);
    apply("R6", 2'd1, 16'h0013, 8'hF2, 1'b1, 2'd2);
    apply("R6", 2'd1, 16'h0013, 8'hF0, 1'b1, 2'd3);
    // R7 CS
    apply("R7", 2'd2, 16'h0008, 8'h9A, 1'b1, 2'd0);
    apply("R7", 2'd2, 16'h000B, 8'h9E, 1'b1, 2'd3);
    apply("R7", 2'd2, 16'h0009, 8'hBE, 1'b1, 2'd1);
    apply("R7", 2'd2, 16'h0008, 8'h1A, 1'b1, 2'd0);
    apply("R7", 2'd2, 16'h0009, 8'h9A, 1'b1, 2'd1);
    // R8 data
    apply("R8", 2'd3, 16'h0010, 8'h92, 1'b1, 2'd0);
    apply("R8", 2'd3, 16'h0013, 8'h9E, 1'b1, 2'd3);
    apply("R8", 2'd3, 16'h0013, 8'h98, 1'b1, 2'd3);
    apply("R8", 2'd3, 16'h0012, 8'hB2, 1'b1, 2'd0);
    apply("R8", 2'd3, 16'h0010, 8'h12, 1'b1, 2'd0);
    // R9 priority: bad type beats absent, bad privilege beats absent
    apply("R9", 2'd1, 16'h0013, 8'h18, 1'b1, 2'd3);
    apply("R9", 2'd1, 16'h0013, 8'h52, 1'b1, 2'd3);
    apply("R9", 2'd2, 16'h0009, 8'h3A, 1'b1, 2'd1);

    for (int i = 0; i < N_RAND; i++) begin
      logic [1:0]  k  = 2'($urandom);
      logic [15:0] s  = 16'($urandom);
      logic [7:0]  a  = 8'($urandom);
      logic        f  = ($urandom % 8) != 0;
      logic [1:0]  cr = 2'($urandom);
      if ($urandom % 8 == 0) s = s & 16'h0003;
      if ($urandom % 2 == 0) a[4] = (k != 2'd0);
      case (k)
        2'd0: apply("R5", k, s, a, f, cr);
        2'd1: apply("R6", k, s, a, f, cr);
        2'd2: apply("R7", k, s, a, f, cr);
        default: apply("R8", k, s, a, f, cr);
      endcase
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule